// File: doc/BRIEF.md
# Serial Input Signature Register

This block compacts a serial test-response stream into a fixed-width signature by performing modulo-2 polynomial division. Each enabled clock shifts one response bit into the register. The register acts as a divider by a characteristic polynomial that is fixed at build time. The bit that leaves the top stage on each shift is a quotient bit, and it is driven on a serial output. After the whole stream has been shifted in, the parallel register contents are the division remainder, which is the signature.

The divider starts from the all-zero state, so the first `WIDTH` shifts after reset only push zeros out of the top stage. A valid strobe marks the enabled cycles whose serial output is a real quotient bit. The quotient and the remainder together are enough to rebuild the input stream. This lets the signature of a known-good circuit be cross-checked by arithmetic, without trusting the register that produced it.

Top module: `sisr_divider`

## Requirements
- R1: While `rst_ni` is low, `rem_o` is all zeros and `quot_vld_o` is 0.
- R2: When `en_i` is low, `rem_o` keeps its value on the next clock and `quot_vld_o` is 0.
- R3: On each clock with `en_i` high, `data_i` enters stage 0 and every other stage takes the stage below it. The bit leaving stage `WIDTH-1` is then XORed into each stage `i` for which bit `i` of `POLY` is 1. `POLY` bit `i` is the coefficient of x^i, and the x^WIDTH term is implied.
- R4: `quot_o` is the bit leaving the top stage in the current cycle. `quot_vld_o` is high exactly on the enabled cycles that come after the first `WIDTH` enabled cycles since reset, so a stream of L bits yields L-WIDTH quotient bits when L is at least WIDTH.
- R5: On every enabled cycle before `quot_vld_o` first rises, `quot_o` is 0.
- R6: The earliest bit of a stream is its highest-order term. After a stream has been shifted in from reset, `rem_o` equals the remainder of that stream polynomial divided by the characteristic polynomial.
- R7: If the valid quotient bits are taken first bit highest, then the characteristic polynomial times the quotient, XORed with `rem_o`, equals the input stream polynomial.
- R8: With `WIDTH`=3 and `POLY`=3'b011 (x^3+x+1), the stream 1101011 gives the quotient 1111 and a remainder of 3'b010.
- R9: By default `WIDTH`=10 and `POLY`=10'h081, which is the characteristic polynomial x^10+x^7+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Shift enable |
| data_i | input | 1 | Serial response bit, highest-order term first |
| quot_o | output | 1 | Serial quotient bit leaving the top stage |
| quot_vld_o | output | 1 | High when quot_o carries a quotient bit |
| rem_o | output | WIDTH | Register contents (remainder / signature) |

## Verification
The assertions assume that `POLY` has a nonzero constant term. They also assume that `data_i` and `en_i` are only meaningful once reset has been released, and that each stream begins at a reset.

The bench applies a reset before every stream. It drives every input only in the low half of the clock period. It sweeps every 8-bit stream, plus longer streams, through 3-, 4- and 10-bit dividers, and inserts idle cycles in a pattern that varies from stream to stream.

// File: rtl/sisr_pkg.sv
package sisr_pkg;
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/sisr_stage.sv
module sisr_stage #(
  parameter bit TAP = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic shift_i,
  input  logic fb_i,
  output logic q_o
);
  logic d;

  generate
    if (TAP) begin : g_tap
      assign d = shift_i ^ fb_i;
    end else begin : g_plain
      assign d = shift_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (en_i) q_o <= d;
  end
endmodule

// File: rtl/sisr_flush_cnt.sv
module sisr_flush_cnt #(
  parameter int unsigned WIDTH = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CW = sisr_pkg::cnt_bits(WIDTH);
  localparam logic [CW-1:0] LIMIT = CW'(WIDTH);

  logic [CW-1:0] cnt;

  // saturates once the initial state has been flushed out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt <= '0;
    else if (en_i && cnt != LIMIT)  cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == LIMIT);

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= LIMIT);
  assert_cnt_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !done_o) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/sisr_divider.sv
module sisr_divider #(
  parameter int unsigned     WIDTH = 10,
  parameter logic [WIDTH-1:0] POLY = 10'h081
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             data_i,
  output logic             quot_o,
  output logic             quot_vld_o,
  output logic [WIDTH-1:0] rem_o
);
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] shift_in;
  logic             fb;
  logic             flushed;

  assign fb = stage_q[WIDTH-1];

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign shift_in[i] = data_i;
      end else begin : g_next
        assign shift_in[i] = stage_q[i-1];
      end
      sisr_stage #(.TAP(POLY[i])) u_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .shift_i (shift_in[i]),
        .fb_i    (fb),
        .q_o     (stage_q[i])
      );
    end
  endgenerate

  sisr_flush_cnt #(.WIDTH(WIDTH)) u_flush (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .done_o (flushed)
  );

  assign quot_o     = fb;
  assign quot_vld_o = en_i & flushed;
  assign rem_o      = stage_q;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_rst_clear_R1: assert (rem_o == '0 && !quot_vld_o);
    end
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rem_o));
  assert_idle_novld_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !quot_vld_o);
  assert_entry_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (rem_o[0] == ($past(data_i) ^ ($past(quot_o) & POLY[0]))));
  assert_vld_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quot_vld_o |=> (!en_i || quot_vld_o));
  assert_flush_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !quot_vld_o) |-> !quot_o);
endmodule

// File: tb/sim_sisr_divider.sv
`timescale 1ns/1ps
module sim_sisr_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic din = 1'b0;

  logic       q0, v0, q1, v1, q2, v2;
  logic [9:0] rem0;
  logic [2:0] rem1;
  logic [3:0] rem2;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sisr_divider u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .data_i(din),
    .quot_o(q0), .quot_vld_o(v0), .rem_o(rem0));
  sisr_divider #(.WIDTH(3), .POLY(3'b011)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .data_i(din),
    .quot_o(q1), .quot_vld_o(v1), .rem_o(rem1));
  sisr_divider #(.WIDTH(4), .POLY(4'b0011)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .data_i(din),
    .quot_o(q2), .quot_vld_o(v2), .rem_o(rem2));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void long_div(input logic [63:0] s, input int len,
                                   input logic [63:0] c, input int deg,
                                   output logic [63:0] q, output logic [63:0] r);
    q = '0;
    for (int d = len - 1; d >= deg; d--) begin
      if (s[d]) begin
        q[d-deg] = 1'b1;
        s = s ^ (c << (d - deg));
      end
    end
    r = s;
  endfunction

  function automatic logic [63:0] clmul(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] acc = '0;
    for (int i = 0; i < 64; i++) if (b[i]) acc = acc ^ (a << i);
    return acc;
  endfunction

  logic [63:0] qa0, qa1, qa2;
  int          nv2;

  task automatic run_stream(input logic [63:0] s, input int len, input logic [63:0] gaps);
    logic [9:0] h0;
    bit flush_bad, hold_bad;
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    @(negedge clk);
    check(rem0 == 0 && rem1 == 0 && rem2 == 0 && !v0 && !v1 && !v2, "R1",
          {rem0, rem1, rem2}, 0);
    rst_n = 1'b1;
    qa0 = '0; qa1 = '0; qa2 = '0; nv2 = 0;
    flush_bad = 0; hold_bad = 0;
    for (int i = len - 1; i >= 0; i--) begin
      if (gaps[i]) begin
        @(negedge clk);
        en = 1'b0; din = ~din; h0 = rem0;
        #1 if (v0 || v1 || v2) hold_bad = 1;
        @(posedge clk);
        #1 if (rem0 != h0) hold_bad = 1;
      end
      @(negedge clk);
      en = 1'b1; din = s[i];
      #1;
      if (v0) qa0 = {qa0[62:0], q0}; else if (q0) flush_bad = 1;
      if (v1) qa1 = {qa1[62:0], q1}; else if (q1) flush_bad = 1;
      if (v2) begin qa2 = {qa2[62:0], q2}; nv2++; end else if (q2) flush_bad = 1;
    end
    @(negedge clk);
    en = 1'b0;
    check(!hold_bad, "R2", {63'd0, hold_bad}, 0);
    check(!flush_bad, "R5", {63'd0, flush_bad}, 0);
  endtask

  initial begin
    logic [63:0] rq, rr, s;
    // R8: worked vector on the 3-bit divider
    run_stream(64'b1101011, 7, 64'd0);
    check(qa1 == 64'b1111, "R8 quotient", qa1, 64'b1111);
    check(rem1 == 3'b010, "R8 remainder", {61'd0, rem1}, 64'b010);
    // R3: one step from zero places the entering bit in stage 0
    run_stream(64'b1, 1, 64'd0);
    check(rem2 == 4'b0001 && rem0 == 10'd1, "R3", {rem0, rem2}, 64'h11);
    // exhaustive 8-bit streams with varying idle gaps
    for (int p = 0; p < 256; p++) begin
      s = 64'(p);
      run_stream(s, 8, 64'((p * 37) & 8'hff));
      long_div(s, 8, 64'h13, 4, rq, rr);
      check(64'(rem2) == rr, "R6", 64'(rem2), rr);
      check(qa2 == rq, "R6 quotient", qa2, rq);
      check(nv2 == 4, "R4", 64'(nv2), 64'd4);
      check((clmul(64'h13, qa2) ^ 64'(rem2)) == s, "R7 w4",
            clmul(64'h13, qa2) ^ 64'(rem2), s);
      check((clmul(64'hb, qa1) ^ 64'(rem1)) == s, "R7 w3",
            clmul(64'hb, qa1) ^ 64'(rem1), s);
      check(64'(rem0) == s, "R9 short", 64'(rem0), s);
    end
    // longer streams through the default 10-bit divider
    for (int k = 0; k < 6; k++) begin
      s = (64'h9e3779b97f4a7c15 * 64'(k + 1)) & 64'hff_ffff_ffff;
      run_stream(s, 40, 64'(k * 64'h1111_1111) & 64'hff_ffff_ffff);
      long_div(s, 40, 64'h481, 10, rq, rr);
      check(64'(rem0) == rr, "R9", 64'(rem0), rr);
      check(qa0 == rq, "R9 quotient", qa0, rq);
      check((clmul(64'h481, qa0) ^ 64'(rem0)) == s, "R7 w10",
            clmul(64'h481, qa0) ^ 64'(rem0), s);
      check(nv2 == 36, "R4 long", 64'(nv2), 64'd36);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule